// File: doc/BRIEF.md
# Video Field Identification Unit

This unit tells a video capture path whether the field now arriving is field 1 or field 2. It raises a one-cycle strobe at the moment each decision is made, and it holds the resulting flag until the next decision. Two decision methods are built in, and a static configuration input picks one of them.

The first method reads a dedicated field-ID pin once per field. The sampling point is one edge of the vertical blanking input, and a configuration bit chooses which edge. A second bit inverts the sampled value. The inversion covers a board whose field-ID polarity is reversed, or a field-ID change that lags the field start.

The second method uses only the active-low HSYNC and VSYNC pins. The unit measures the distance between their falling edges. If the two edges lie within a symmetric window of 64 clocks, in either order, the unit reports field 1. Otherwise it reports field 2. All four pins pass through a two-flop synchronizer before any edge detection.

Top module: `vid_field_ident`

## Requirements
- R1: While `rst` is high on a clock edge, `field2` becomes 0 (field 1) and `field_start` becomes 0. Any pending sync window and the HSYNC distance counter are cleared.
- R2: With `method_sel`=0 and `start_sel`=0, a rising edge on `vblank` marks a field start. At that point `field2` takes the value of `field_id` (0 means field 1, 1 means field 2), and `field_start` pulses.
- R3: With `method_sel`=0 and `start_sel`=1, the falling edge of `vblank` is the sampling point. The rising edge then causes no decision.
- R4: With `id_invert`=1, the sampled `field_id` value is inverted before it is stored in `field2`.
- R5: Changes on `field_id` away from the selected `vblank` edge leave `field2` unchanged and produce no strobe.
- R6: With `method_sel`=1, a falling edge of `vsync_n` that occurs 0 to 64 clocks after a falling edge of `hsync_n` gives field 1. The decision is taken at the `vsync_n` edge.
- R7: With `method_sel`=1, a falling edge of `hsync_n` that occurs 1 to 64 clocks after a falling edge of `vsync_n` gives field 1. The decision is taken at that `hsync_n` edge.
- R8: If no `hsync_n` falling edge lies within 64 clocks on either side of a `vsync_n` falling edge, the unit reports field 2. This decision is taken 64 clocks after the `vsync_n` edge, and a later `hsync_n` edge does not revise it.
- R9: In both orders, an edge distance of exactly 64 clocks gives field 1 and a distance of 65 clocks gives field 2.
- R10: `field_start` is high for exactly one cycle per decision, and `field2` changes only in a cycle where `field_start` is high. Take an input edge first sampled at clock edge n. A decision taken at that sample appears at the outputs after clock edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous reset, active high |
| method_sel | input | 1 | 0: field-ID pin method, 1: sync-edge comparison method |
| field_id | input | 1 | Field-ID pin |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| vblank | input | 1 | Vertical blanking, active high |
| start_sel | input | 1 | Field start point: 0 start of blanking, 1 end of blanking |
| id_invert | input | 1 | Invert the sampled field-ID value |
| field2 | output | 1 | Current field: 0 field 1, 1 field 2 |
| field_start | output | 1 | One-cycle strobe when a field decision is made |

## Verification
The hardest situations to reach are the window boundaries, where the two sync edges lie exactly 64 or 65 clocks apart. The case where VSYNC leads is especially hard, because the outcome then hangs on whether the HSYNC edge lands before or after the window closes. The stimulus places each edge at a computed cycle offset for both orders. Each case is surrounded by long idle gaps, so no earlier HSYNC edge is still inside the window. The behavioural model compares the outputs on every cycle, and it counts strobes per case, which shows that a late HSYNC after an expiry does not trigger a second decision.

// File: rtl/vfi_pkg.sv
package vfi_pkg;

   typedef enum logic {
      METH_ID_PIN  = 1'b0,
      METH_SYNC_CMP = 1'b1
   } vfi_method_e;

   typedef enum logic {
      START_BLANK_BEGIN = 1'b0,
      START_BLANK_END   = 1'b1
   } vfi_start_e;

   typedef struct packed {
      logic valid;
      logic field2;
   } vfi_decision_t;

   // bit positions inside the synchronized pin vector
   localparam int PIN_HS  = 0;
   localparam int PIN_VS  = 1;
   localparam int PIN_VB  = 2;
   localparam int PIN_FID = 3;
   localparam int PIN_CNT = 4;

endpackage

// File: rtl/vfi_sync.sv
module vfi_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [WIDTH-1:0] dprev
);

   initial assert (STAGES >= 1) else $error("vfi_sync: STAGES must be at least 1");
   initial assert (WIDTH >= 1) else $error("vfi_sync: WIDTH must be at least 1");

   // STAGES synchronizer flops plus one history stage for edge detection
   logic [STAGES:0][WIDTH-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i <= STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= din;
         for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout  = stg[STAGES-1];
   assign dprev = stg[STAGES];

endmodule

// File: rtl/vfi_fid_sampler.sv
module vfi_fid_sampler
   import vfi_pkg::*;
(
   input  logic          vb_now,
   input  logic          vb_prev,
   input  logic          fid_now,
   input  vfi_start_e    start_pt,
   input  logic          invert,
   output vfi_decision_t dec
);

   logic vb_rise, vb_fall, at_start;

   always_comb begin
      vb_rise  = vb_now & ~vb_prev;
      vb_fall  = ~vb_now & vb_prev;
      at_start = (start_pt == START_BLANK_END) ? vb_fall : vb_rise;
      dec.valid  = at_start;
      dec.field2 = fid_now ^ invert;
   end

endmodule

// File: rtl/vfi_sync_compare.sv
module vfi_sync_compare
   import vfi_pkg::*;
#(
   parameter int WIN = 64
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hs_now,
   input  logic          hs_prev,
   input  logic          vs_now,
   input  logic          vs_prev,
   output vfi_decision_t dec
);

   localparam int SAT_I = WIN + 1;
   localparam int CNT_W = $clog2(SAT_I + 1);
   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT_I);
   localparam logic [CNT_W-1:0] WIN_V = CNT_W'(WIN);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   initial assert (WIN >= 1) else $error("vfi_sync_compare: WIN must be at least 1");

   logic             h_fall, v_fall;
   logic [CNT_W-1:0] hcnt;     // clocks since last HSYNC leading edge, saturating
   logic             armed;    // look-ahead window open after a lone VSYNC edge
   logic [CNT_W-1:0] wcnt;     // clocks since the VSYNC edge that armed the window
   logic             arm_set;

   assign h_fall = hs_prev & ~hs_now;
   assign v_fall = vs_prev & ~vs_now;

   always_comb begin
      dec     = '0;
      arm_set = 1'b0;
      if (v_fall) begin
         if (h_fall || (hcnt <= WIN_V)) begin
            dec.valid  = 1'b1;
            dec.field2 = 1'b0;
         end else begin
            arm_set = 1'b1;
         end
      end else if (armed) begin
         if (h_fall) begin
            dec.valid  = 1'b1;
            dec.field2 = 1'b0;
         end else if (wcnt == WIN_V) begin
            dec.valid  = 1'b1;
            dec.field2 = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hcnt <= SAT_V;
      end else if (h_fall) begin
         hcnt <= ONE_V;
      end else if (hcnt != SAT_V) begin
         hcnt <= hcnt + ONE_V;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         armed <= 1'b0;
         wcnt  <= '0;
      end else if (arm_set) begin
         armed <= 1'b1;
         wcnt  <= ONE_V;
      end else if (armed && dec.valid) begin
         armed <= 1'b0;
      end else if (armed) begin
         wcnt  <= wcnt + ONE_V;
      end
   end

   // R6: the distance counter never runs past its saturation value
   a_r6_hcnt_saturates: assert property (@(posedge clk) disable iff (rst)
      hcnt <= SAT_V);

   // R8: an open window always lies within the look-ahead span
   a_r8_window_bounded: assert property (@(posedge clk) disable iff (rst)
      armed |-> (wcnt >= ONE_V && wcnt <= WIN_V));

   // R7: the window opens only after a VSYNC leading edge
   a_r7_arm_on_vsync: assert property (@(posedge clk) disable iff (rst)
      $rose(armed) |-> $past(v_fall));

   // R9: a window at its last clock closes unless a new VSYNC edge reopens it
   a_r9_window_closes: assert property (@(posedge clk) disable iff (rst)
      (armed && wcnt == WIN_V && !v_fall) |=> !armed);

endmodule

// File: rtl/vid_field_ident.sv
module vid_field_ident
   import vfi_pkg::*;
#(
   parameter int WIN         = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic method_sel,
   input  logic field_id,
   input  logic hsync_n,
   input  logic vsync_n,
   input  logic vblank,
   input  logic start_sel,
   input  logic id_invert,
   output logic field2,
   output logic field_start
);

   localparam logic [PIN_CNT-1:0] PIN_IDLE = PIN_CNT'(4'b0011);

   initial assert (SYNC_STAGES >= 2) else $error("vid_field_ident: need two synchronizer stages");

   logic [PIN_CNT-1:0] pins_raw, pins_s, pins_p;
   vfi_decision_t      dec_id, dec_sync, dec_sel;

   assign pins_raw = {field_id, vblank, vsync_n, hsync_n};

   vfi_sync #(
      .WIDTH   (PIN_CNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst   (rst),
      .din   (pins_raw),
      .dout  (pins_s),
      .dprev (pins_p)
   );

   vfi_fid_sampler u_id (
      .vb_now   (pins_s[PIN_VB]),
      .vb_prev  (pins_p[PIN_VB]),
      .fid_now  (pins_s[PIN_FID]),
      .start_pt (vfi_start_e'(start_sel)),
      .invert   (id_invert),
      .dec      (dec_id)
   );

   vfi_sync_compare #(
      .WIN (WIN)
   ) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .hs_now  (pins_s[PIN_HS]),
      .hs_prev (pins_p[PIN_HS]),
      .vs_now  (pins_s[PIN_VS]),
      .vs_prev (pins_p[PIN_VS]),
      .dec     (dec_sync)
   );

   assign dec_sel = (vfi_method_e'(method_sel) == METH_SYNC_CMP) ? dec_sync : dec_id;

   always_ff @(posedge clk) begin
      if (rst) begin
         field2      <= 1'b0;
         field_start <= 1'b0;
      end else begin
         field_start <= dec_sel.valid;
         if (dec_sel.valid) field2 <= dec_sel.field2;
      end
   end

   // R1: reset forces field 1 and no strobe
   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (!field2 && !field_start));

   // R10: the flag moves only together with the strobe
   a_r10_flag_with_strobe: assert property (@(posedge clk) disable iff (rst)
      !$stable(field2) |-> field_start);

   // R5: in pin mode without a strobe the flag holds
   a_r5_hold_without_start: assert property (@(posedge clk) disable iff (rst)
      (!method_sel && !field_start) |-> $stable(field2));

endmodule

// File: tb/vid_field_ident_tb.sv
module vid_field_ident_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int WIN = 64;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic method_sel = 1'b0;
   logic field_id = 1'b0;
   logic hsync_n = 1'b1;
   logic vsync_n = 1'b1;
   logic vblank = 1'b0;
   logic start_sel = 1'b0;
   logic id_invert = 1'b0;
   logic field2, field_start;

   int n_cmp = 0;
   int n_bad = 0;
   int strobes = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;   // 125 MHz

   vid_field_ident #(.WIN(WIN), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst(rst), .method_sel(method_sel), .field_id(field_id),
      .hsync_n(hsync_n), .vsync_n(vsync_n), .vblank(vblank),
      .start_sel(start_sel), .id_invert(id_invert),
      .field2(field2), .field_start(field_start)
   );

   // ---------------- behavioural reference model ----------------
   int  sidx = 0;
   int  last_h;
   int  vtime;
   bit  pend;
   bit  hp, vp, bp;
   bit  cur;
   bit  e0f, e1f, e2f, e0s, e1s, e2s;
   int  since_rst = 0;

   always @(posedge clk) begin
      bit hf, vf, dv, df, sv, sf, iv, ifd;
      sidx++;
      if (rst) begin
         last_h = sidx - 1000000; pend = 0; vtime = 0;
         hp = 1; vp = 1; bp = 0; cur = 0;
         e0f = 0; e1f = 0; e2f = 0; e0s = 0; e1s = 0; e2s = 0;
         since_rst = 0;
      end else begin
         hf = hp && !hsync_n;
         vf = vp && !vsync_n;
         sv = 0; sf = 0;
         if (vf) begin
            if (hf || (sidx - last_h) <= WIN) begin sv = 1; sf = 0; pend = 0; end
            else begin pend = 1; vtime = sidx; end
         end else if (pend) begin
            if (hf) begin sv = 1; sf = 0; pend = 0; end
            else if (sidx - vtime == WIN) begin sv = 1; sf = 1; pend = 0; end
         end
         if (hf) last_h = sidx;
         iv  = start_sel ? (bp && !vblank) : (!bp && vblank);
         ifd = field_id ^ id_invert;
         dv = method_sel ? sv : iv;
         df = method_sel ? sf : ifd;
         if (dv) cur = df;
         e2f = e1f; e2s = e1s;
         e1f = e0f; e1s = e0s;
         e0f = cur; e0s = dv;
         hp = hsync_n; vp = vsync_n; bp = vblank;
         since_rst++;
      end
   end

   always @(negedge clk) begin
      if (!rst && since_rst >= 1) begin
         n_cmp++;
         if (field2 !== e2f || field_start !== e2s) begin
            n_bad++;
            $display("FAIL %s cycle model: field2=%b start=%b expected field2=%b start=%b",
                     cur_req, field2, field_start, e2f, e2s);
         end
         if (field_start === 1'b1) strobes++;
      end
   end

   // ---------------- helpers ----------------
   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // h_first=1: HSYNC edge then VSYNC edge d clocks later; else reverse
   task automatic sync_case(input string req, input bit h_first, input int d, input bit exp_f2);
      int th, tv, len;
      cur_req = req;
      th = h_first ? 2 : 2 + d;
      tv = h_first ? 2 + d : 2;
      len = (th > tv ? th : tv) + 100;
      strobes = 0;
      for (int c = 0; c < len; c++) begin
         hsync_n = !(c >= th && c < th + 4);
         vsync_n = !(c >= tv && c < tv + 20);
         @(negedge clk);
      end
      hsync_n = 1; vsync_n = 1;
      step(50);
      check(req, $sformatf("field2 after edges %0d apart", d), int'(field2), int'(exp_f2));
      check("R10", "strobes per sync case", strobes, 1);
   endtask

   task automatic blank_pulse(input string req, input bit fid_rise, input bit fid_fall,
                              input int exp_f2, input int exp_strobes);
      cur_req = req;
      strobes = 0;
      field_id = fid_rise;
      step(3);
      vblank = 1;
      step(10);
      field_id = fid_fall;
      step(10);
      vblank = 0;
      step(15);
      check(req, "field2 after blanking pulse", int'(field2), exp_f2);
      check("R10", "strobes per blanking pulse", strobes, exp_strobes);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      step(3);
      check("R1", "field2 in reset", int'(field2), 0);
      check("R1", "strobe in reset", int'(field_start), 0);
      rst = 0;
      step(5);

      // field-ID pin method
      method_sel = 0; start_sel = 0; id_invert = 0;
      step(5);
      blank_pulse("R2", 1, 1, 1, 1);
      cur_req = "R5";
      strobes = 0;
      field_id = 0; step(7); field_id = 1; step(4); field_id = 0; step(10);
      check("R5", "field2 after stray id toggles", int'(field2), 1);
      check("R5", "strobes after stray id toggles", strobes, 0);
      blank_pulse("R2", 0, 0, 0, 1);
      id_invert = 1; step(5);
      blank_pulse("R4", 0, 0, 1, 1);
      id_invert = 0; start_sel = 1; step(5);
      blank_pulse("R3", 1, 0, 0, 1);
      blank_pulse("R3", 0, 1, 1, 1);

      // reset mid-run
      cur_req = "R1";
      rst = 1;
      step(2);
      check("R1", "field2 during mid reset", int'(field2), 0);
      check("R1", "strobe during mid reset", int'(field_start), 0);
      rst = 0;
      start_sel = 0;
      step(5);

      // sync-edge comparison method
      method_sel = 1;
      step(100);
      sync_case("R6", 1, 10, 0);
      sync_case("R8", 1, 200, 1);
      sync_case("R6", 1, 0, 0);
      sync_case("R9", 1, 65, 1);
      sync_case("R9", 1, 64, 0);
      sync_case("R8", 0, 100, 1);
      sync_case("R7", 0, 5, 0);
      sync_case("R9", 0, 65, 1);
      sync_case("R9", 0, 64, 0);

      step(10);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finished (%s)", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule